// File: doc/BRIEF.md
# Tone Burst Gating Controller

This block generates the on/off tone waveform for several independent output channels of a supply regulator. The tone is 22 kHz nominal. It is not made from an arbitrary clock. It is divided from the converter oscillator, which runs at twenty times the tone rate. Dividing that clock by 20 gives a square wave that is high for 10 oscillator cycles and low for 10.

Each channel has two register bits, a tone-enable bit and an external-mode bit, and one external modulation pin. These select one of three tone sources:

- **Continuous mode:** the channel outputs the tone without stopping.
- **Gated mode:** the pin switches the internally divided tone on and off, which is how bursts are coded.
- **Pass-through mode:** the pin already carries a modulated tone, and it is forwarded to the output.

Each pin passes through a two-flop synchronizer. Every tone output is a register clocked by the oscillator.

The register bits are assumed to be static, or to change only while reset is held. The analog shaping of the waveform, the serial register interface and the tone detector belong to other blocks.

Top module: `tone_burst_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `tone_out` is 0 from the first clock edge on, and every divider is cleared.
- R2: With `tone_en[i]`=1, `tone_out[i]` after the m-th rising edge following reset release is 1 when ((m-1) mod 20) < 10, and 0 otherwise. That is a period of 20 cycles that is high for 10, and it starts high.
- R3: With `tone_en[i]`=1, the value of `mod_pin[i]` has no effect on `tone_out[i]`.
- R4: With `tone_en[i]`=1 and `mode_ext[i]`=1 at the same time, the channel behaves exactly as in R2. The tone-enable bit wins.
- R5: In gated mode (`tone_en[i]`=0, `mode_ext[i]`=0), let k be the first edge of a run of edges that sample `mod_pin[i]`=1. Then the output after edge m, for m ≥ k+2, is 1 when ((m-k-2) mod 20) < 10, as long as the pin was still sampled high at edge m-2. Every burst therefore starts at divider phase zero, with a full 10-cycle high half.
- R6: In gated mode, if `mod_pin[i]` is sampled low at edge j, then `tone_out[i]` is 0 after edge j+2. The tone stops at once, even in the middle of a half-cycle.
- R7: In pass-through mode (`tone_en[i]`=0, `mode_ext[i]`=1), the value of `mod_pin[i]` sampled at edge j appears on `tone_out[i]` after edge j+2. Edges sampled before the first edge after reset count as 0.
- R8: The channels are independent. A channel's output depends only on its own enable bit, mode bit and pin, even when neighbouring channels run in different modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Converter oscillator clock, twenty times the tone rate |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_en | input | NUM_CH | Per-channel continuous-tone enable register bit |
| mode_ext | input | NUM_CH | Per-channel external-mode register bit (pass-through when set) |
| mod_pin | input | NUM_CH | Per-channel asynchronous external modulation pin |
| tone_out | output | NUM_CH | Per-channel tone output, registered |

## Verification
The bench sweeps burst lengths from 1 to 24 cycles with varying gaps. A divider that did not restart at phase zero would start some bursts in the middle of a half-cycle or on a low half. A gate that closed only at the end of a half-cycle would stretch one-cycle bursts.

Continuous mode is driven with random pin activity, once alone and once with the external-mode bit also set. A wrong priority between the two bits would let the pin leak through.

Pass-through is checked against random pin streams at exactly two cycles of latency after sampling. An extra or a missing synchronizer stage would shift every sample.

One run mixes modes across the channels. A divider or synchronizer shared by mistake would show up there as cross-talk.

// File: rtl/tone_burst_pkg.sv
// Package: tone_burst_pkg
// Holds the shared tone-source type and the decode of the two register
// bits into that type. Assumes the enable bit takes priority over the
// external-mode bit.
package tone_burst_pkg;

    typedef enum logic [1:0] {
        SRC_CONT  = 2'd0,
        SRC_GATED = 2'd1,
        SRC_PASS  = 2'd2
    } tone_src_e;

    // Map enable and external-mode bits to a tone source.
    function automatic tone_src_e decode_src(input logic en, input logic ext);
        if (en)
            return SRC_CONT;
        else if (ext)
            return SRC_PASS;
        else
            return SRC_GATED;
    endfunction

endpackage

// File: rtl/tbg_pin_sync.sv
// Module: tbg_pin_sync
// Multi-flop synchronizer that brings an asynchronous pin into the
// oscillator clock domain. Assumes STAGES >= 2. Cleared by reset.
module tbg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], pin_async};
    end

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tbg_divider.sv
// Module: tbg_divider
// Divides the oscillator by DIV_RATIO while the gate is open and
// reports the high half of the tone period. A closed gate holds the
// count at phase zero, so every opening begins with a full high half.
// Assumes DIV_RATIO is even and at least 2.
module tbg_divider #(
    parameter int DIV_RATIO = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_open,
    output logic phase_hi
);

    localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(DIV_RATIO - 1);
    localparam logic [CNT_W-1:0] HALF_V = CNT_W'(DIV_RATIO / 2);

    logic [CNT_W-1:0] cnt_q;

    // Advance the phase counter while the gate is open, else hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!gate_open)
            cnt_q <= '0;
        else if (cnt_q == LAST_V)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign phase_hi = gate_open && (cnt_q < HALF_V);

endmodule

// File: rtl/tbg_channel.sv
// Module: tbg_channel
// One tone channel: synchronizes its pin, decodes its source, gates its
// own divider and registers the selected tone. Assumes the register
// bits are static outside reset.
module tbg_channel
    import tone_burst_pkg::*;
#(
    parameter int DIV_RATIO   = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_bit,
    input  logic ext_bit,
    input  logic pin_async,
    output logic tone_q
);

    tone_src_e src;
    logic      pin_s;
    logic      gate_open;
    logic      phase_hi;
    logic      tone_d;

    tbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_async),
        .pin_sync  (pin_s)
    );

    // Decode source and open the divider gate for internal-tone modes.
    always_comb begin
        src       = decode_src(en_bit, ext_bit);
        gate_open = (src == SRC_CONT) || ((src == SRC_GATED) && pin_s);
    end

    tbg_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_open (gate_open),
        .phase_hi  (phase_hi)
    );

    // Select divided tone or the synchronized external tone.
    always_comb begin
        tone_d = (src == SRC_PASS) ? pin_s : phase_hi;
    end

    // Register the channel output; reset drives it low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tone_q <= 1'b0;
        else
            tone_q <= tone_d;
    end

endmodule

// File: rtl/tone_burst_gate.sv
// Module: tone_burst_gate
// Top of the tone burst gating controller: NUM_CH independent channels,
// each producing a tone at the oscillator rate divided by DIV_RATIO.
// Assumes clk_osc is the converter oscillator, mod_pin is asynchronous,
// and reset is synchronous and active low.
module tone_burst_gate #(
    parameter int NUM_CH      = 2,
    parameter int DIV_RATIO   = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_osc,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tone_en,
    input  logic [NUM_CH-1:0] mode_ext,
    input  logic [NUM_CH-1:0] mod_pin,
    output logic [NUM_CH-1:0] tone_out
);

    // One channel instance per output.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tbg_channel #(
            .DIV_RATIO   (DIV_RATIO),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk       (clk_osc),
            .rst_n     (rst_n),
            .en_bit    (tone_en[ch]),
            .ext_bit   (mode_ext[ch]),
            .pin_async (mod_pin[ch]),
            .tone_q    (tone_out[ch])
        );
    end

endmodule

// File: rtl/tone_burst_gate_chk.sv
// Module: tone_burst_gate_chk
// Checker bound to tone_burst_gate. Tracks cycles since reset and run
// lengths of each output, and checks reset, continuous, gated and
// pass-through timing. Assumes the default two-stage synchronizer.
module tone_burst_gate_chk #(
    parameter int NUM_CH    = 2,
    parameter int DIV_RATIO = 20
) (
    input logic              clk_osc,
    input logic              rst_n,
    input logic [NUM_CH-1:0] tone_en,
    input logic [NUM_CH-1:0] mode_ext,
    input logic [NUM_CH-1:0] mod_pin,
    input logic [NUM_CH-1:0] tone_out
);

    logic [1:0]        since_q;
    logic [NUM_CH-1:0] tone_prev_q;

    // Count cycles out of reset, saturating at 3.
    always_ff @(posedge clk_osc) begin
        if (!rst_n)
            since_q <= 2'd0;
        else if (since_q != 2'd3)
            since_q <= since_q + 2'd1;
    end

    // Remember the previous output value.
    always_ff @(posedge clk_osc) begin
        tone_prev_q <= tone_out;
    end

    // R1: one edge with reset low forces every output low.
    a_r1_reset_low: assert property (@(posedge clk_osc)
        !rst_n |=> (tone_out == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [15:0] run_q;

        // Length of the current run of equal output values.
        always_ff @(posedge clk_osc) begin
            if (!rst_n)
                run_q <= 16'd0;
            else if (tone_out[i] != tone_prev_q[i])
                run_q <= 16'd1;
            else if (run_q != 16'hFFFF)
                run_q <= run_q + 16'd1;
        end

        // R2: continuous tone never holds a level longer than half a period.
        a_r2_half_limit: assert property (@(posedge clk_osc) disable iff (!rst_n)
            tone_en[i] |-> (run_q <= 16'(DIV_RATIO / 2)));

        // R5: a pin rising into the gate starts the tone high.
        a_r5_burst_start: assert property (@(posedge clk_osc) disable iff (!rst_n)
            (since_q == 2'd3 && !tone_en[i] && !mode_ext[i]
             && $past(mod_pin[i], 3) && !$past(mod_pin[i], 4))
            |-> tone_out[i]);

        // R6: a low pin in gated mode silences the output.
        a_r6_gate_close: assert property (@(posedge clk_osc) disable iff (!rst_n)
            (since_q == 2'd3 && !tone_en[i] && !mode_ext[i] && !$past(mod_pin[i], 3))
            |-> !tone_out[i]);

        // R7: pass-through output follows the pin with fixed latency.
        a_r7_pass_follow: assert property (@(posedge clk_osc) disable iff (!rst_n)
            (since_q == 2'd3 && !tone_en[i] && mode_ext[i])
            |-> (tone_out[i] == $past(mod_pin[i], 3)));
    end

endmodule

bind tone_burst_gate tone_burst_gate_chk #(
    .NUM_CH    (NUM_CH),
    .DIV_RATIO (DIV_RATIO)
) u_chk (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .tone_en  (tone_en),
    .mode_ext (mode_ext),
    .mod_pin  (mod_pin),
    .tone_out (tone_out)
);

// File: tb/tone_burst_gate_tb.sv
// Bench for tone_burst_gate: per-cycle expected values computed from
// the requirement formulas and a record of sampled pin values.
module tone_burst_gate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int DIV        = 20;
    localparam int HALF       = DIV / 2;
    localparam int HMAX       = 4096;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] en = '0;
    logic [NCH-1:0] ms = '0;
    logic [NCH-1:0] pin = '0;
    logic [NCH-1:0] tone;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit hist [NCH][HMAX];
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tone_burst_gate #(.NUM_CH(NCH), .DIV_RATIO(DIV), .SYNC_STAGES(2)) u_dut (
        .clk_osc  (clk),
        .rst_n    (rst_n),
        .tone_en  (en),
        .mode_ext (ms),
        .mod_pin  (pin),
        .tone_out (tone)
    );

    // Expected output after edge m from the requirement formulas.
    function automatic bit expect_tone(input int ch, input int m);
        int k;
        if (en[ch])
            return (((m - 1) % DIV) < HALF);          // R2 / R4
        if (ms[ch])
            return (m - 2 >= 1) ? hist[ch][m - 2] : 1'b0;  // R7
        if (m - 2 < 1 || !hist[ch][m - 2])
            return 1'b0;                                // R6
        k = m - 2;
        while (k > 1 && hist[ch][k - 1])
            k--;
        return (((m - k - 2) % DIV) < HALF);          // R5
    endfunction

    function automatic string tag_for(input int ch, input bit exp_v);
        if (en[ch] && ms[ch]) return "R4";
        if (en[ch])           return "R3";
        if (ms[ch])           return "R7";
        return exp_v ? "R5" : "R6";
    endfunction

    task automatic check_bit(input string req, input bit act, input bit exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: cycle %0d actual %0b expected %0b", req, cyc, act, exp_v);
        end
    endtask

    task automatic do_reset(input logic [NCH-1:0] e, input logic [NCH-1:0] m);
        rst_n = 1'b0;
        en    = e;
        ms    = m;
        for (int i = 0; i < 3; i++) begin
            pin = NCH'($urandom);
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++)
                check_bit("R1", tone[ch], 1'b0);
        end
        for (int ch = 0; ch < NCH; ch++)
            for (int i = 0; i < HMAX; i++)
                hist[ch][i] = 1'b0;
        pin   = '0;
        rst_n = 1'b1;
        cyc   = 0;
    endtask

    // Drive pins for the next edge, then check every channel after it.
    task automatic step(input logic [NCH-1:0] p, input string over);
        bit e_v;
        pin = p;
        for (int ch = 0; ch < NCH; ch++)
            hist[ch][cyc + 1] = p[ch];
        @(posedge clk);
        cyc++;
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) begin
            e_v = expect_tone(ch, cyc);
            check_bit((over != "") ? over : tag_for(ch, e_v), tone[ch], e_v);
        end
    endtask

    initial begin
        // R1 reset, then R2/R3 on ch0 and R4 on ch1 with random pins.
        do_reset(2'b11, 2'b10);
        for (int i = 0; i < 5; i++)
            step(2'b00, "R2");
        for (int i = 0; i < 100; i++)
            step(NCH'($urandom), "");

        // R5/R6 gated sweep: ch0 burst lengths 1..24, ch1 long slow bursts.
        do_reset(2'b00, 2'b00);
        for (int len = 1; len <= 24; len++) begin
            for (int i = 0; i < len; i++)
                step({1'((cyc / 37) % 2), 1'b1}, "");
            for (int i = 0; i < (len % 5) + 1; i++)
                step({1'((cyc / 37) % 2), 1'b0}, "");
        end
        for (int i = 0; i < 30; i++)
            step({1'((cyc / 37) % 2), 1'b0}, "");

        // R7 pass-through on both channels.
        do_reset(2'b00, 2'b11);
        for (int i = 0; i < 200; i++)
            step(NCH'($urandom), "");

        // R8 mixed modes: ch0 pass-through, ch1 gated.
        do_reset(2'b00, 2'b01);
        for (int i = 0; i < 300; i++)
            step({1'((cyc / 13) % 3 != 0), 1'($urandom)}, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule